// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port through which an external host, running on its own clock, reads and writes a processor's on-chip program memory and data memory. The host uses one 16-bit bus for both addresses and data. It first runs an address phase, which sets a start address and a memory-type bit. It then runs any number of read or write data phases. The internal pointer advances on its own after every completed word, so a sequential block needs only its start address.

Each host strobe passes through a two-flop synchronizer into the core clock. Each word then claims one core memory slot through a request/grant pair. The acknowledge output stays low while a request waits for its slot.

Program words are 24 bits wide and cross the bus as two transfers: the upper 16 bits first, then the low byte. Reads are served from a prefetch register holding the word at the current address. The next word is fetched as soon as the pointer advances. Data-memory writes that fall on the control-register window at the top of the data space are discarded.

Top module: `hostmem_port`

## Requirements
- R1: After reset `h_ack` is 1, `mem_req` is 0 and `h_bus_oe` is 0.
- R2: A falling edge of `h_latch` loads the pointer from `h_bus_in[13:0]` and the memory type from `h_bus_in[14]` (1 = program memory, 0 = data memory). The word at that address is then fetched into the prefetch register.
- R3: A data-memory write transfer stores `h_bus_in[15:0]` at the current address and then advances the pointer by one.
- R4: A data-memory read transfer returns the word at the current address on `h_bus_out[15:0]` and then advances the pointer by one. A burst therefore returns consecutive words.
- R5: A program-memory write takes two transfers. The first transfer supplies bits 23:8 and causes no memory write. The second transfer supplies bits 7:0 in `h_bus_in[7:0]`, and its upper byte is ignored. One 24-bit write follows, and the pointer advances only after the second transfer.
- R6: A program-memory read takes two transfers. The first returns bits 23:8 of the word. The second returns `{8'h00, bits 7:0}` and advances the pointer.
- R7: A data-memory write to an address at or above 2^14 − 32 (16352..16383) issues no memory write. The pointer still advances, so a later read of that location returns its old contents.
- R8: Each word costs exactly one granted core memory cycle. `mem_req` stays high with stable address and direction until `mem_gnt`. A burst of N data writes uses N grants.
- R9: `h_ack` is low whenever `mem_req` is high. It falls after a transfer strobe is seen and rises again once the transfer has finished.
- R10: The control-register protection applies only to data memory. Program-memory writes to addresses 16352..16383 take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_bus_in | input | 16 | Host bus: address/type in address phase, data in write phase |
| h_bus_out | output | 16 | Read data toward host |
| h_bus_oe | output | 1 | Host bus drive enable during reads |
| h_latch | input | 1 | Address-latch strobe, captured on its falling edge |
| h_sel | input | 1 | Port select strobe |
| h_rd | input | 1 | Read strobe (qualified by select) |
| h_wr | input | 1 | Write strobe (qualified by select) |
| h_ack | output | 1 | Acknowledge; low while a transfer is in progress |
| mem_req | output | 1 | Core memory slot request |
| mem_we | output | 1 | Request is a write |
| mem_pm | output | 1 | Request targets program memory |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Write data (data-memory words zero-extended) |
| mem_gnt | input | 1 | Slot granted; the access takes place in this cycle |
| mem_rdata | input | 24 | Read data, valid the cycle after the grant |

## Verification
The bench builds the port with its defaults: a 14-bit address space and a 32-word control window. A sparse memory model lets the bench write and read the very top of both spaces. That puts both edges of the protected window (16351 and 16352) within reach, along with the program-memory counterpart at 16383. The grant model can run with grants every third cycle or every seventh cycle. The slower setting holds requests pending for several cycles, which exercises the acknowledge and the held-request behaviour.

// File: rtl/hostmem_pkg.sv
package hostmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_REQ,
        ST_RD_REQ,
        ST_RD_CAP
    } hm_state_t;

    typedef struct packed {
        logic al_fall;
        logic wr_rise;
        logic rd_rise;
        logic rd_level;
    } hm_evt_t;

    function automatic logic in_ctrl_window(input logic [13:0] addr, input int limit);
        return int'(addr) >= limit;
    endfunction

endpackage

// File: rtl/hostmem_sync.sv
module hostmem_sync
    import hostmem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    h_latch,
    input  logic    h_sel,
    input  logic    h_rd,
    input  logic    h_wr,
    output hm_evt_t evt
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] chain [STAGES];
    logic [NSIG-1:0] prev;
    logic [NSIG-1:0] lvl;

    assign raw = {h_latch, h_sel & h_wr, h_sel & h_rd};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else if (g == 0) chain[g] <= raw;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign lvl = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else prev <= lvl;
    end

    assign evt.al_fall  = prev[2] & ~lvl[2];
    assign evt.wr_rise  = lvl[1] & ~prev[1];
    assign evt.rd_rise  = lvl[0] & ~prev[0];
    assign evt.rd_level = lvl[0];

endmodule

// File: rtl/hostmem_ptr.sv
module hostmem_ptr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_pm,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              pm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            pm   <= 1'b0;
        end else if (load) begin
            addr <= load_addr;
            pm   <= load_pm;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr == $past(load_addr) && pm == $past(load_pm)));

    a_r4_inc_by_one: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (addr == $past(addr) + 1'b1 && $stable(pm)));

endmodule

// File: rtl/hostmem_engine.sv
module hostmem_engine
    import hostmem_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BUS_W  = 16,
    parameter int WORD_W = 24,
    parameter int LIMIT  = 16352
) (
    input  logic              clk,
    input  logic              rst,
    input  hm_evt_t           evt,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pm,
    output logic              ptr_load,
    output logic              ptr_inc,
    output logic [BUS_W-1:0]  bus_out,
    output logic              ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int LOW_W = WORD_W - BUS_W;

    hm_state_t         state;
    logic              half;
    logic              wr_pend, rd_pend;
    logic [BUS_W-1:0]  wbuf, hold;
    logic [WORD_W-1:0] pf;
    logic              pf_valid;

    wire idle      = (state == ST_IDLE);
    wire do_load   = idle && evt.al_fall;
    wire wr_go     = idle && !evt.al_fall && wr_pend;
    wire rd_go     = idle && !evt.al_fall && !wr_pend && rd_pend && pf_valid;
    wire wr_first  = pm && !half;
    wire wr_block  = !pm && in_ctrl_window(addr, LIMIT);

    assign ptr_load = do_load;
    assign ptr_inc  = (wr_go && !wr_first && wr_block)
                    || (rd_go && !(pm && !half))
                    || (state == ST_WR_REQ && mem_gnt);

    assign mem_req   = (state == ST_WR_REQ) || (state == ST_RD_REQ);
    assign mem_we    = (state == ST_WR_REQ);
    assign mem_wdata = pm ? {hold, wbuf[LOW_W-1:0]} : {{LOW_W{1'b0}}, wbuf};
    assign ack       = idle && !wr_pend && !rd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            half     <= 1'b0;
            wr_pend  <= 1'b0;
            rd_pend  <= 1'b0;
            wbuf     <= '0;
            hold     <= '0;
            pf       <= '0;
            pf_valid <= 1'b0;
            bus_out  <= '0;
        end else begin
            if (evt.wr_rise) begin
                wr_pend <= 1'b1;
                wbuf    <= bus_in;
            end
            if (evt.rd_rise) rd_pend <= 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (do_load) begin
                        half     <= 1'b0;
                        pf_valid <= 1'b0;
                        state    <= ST_RD_REQ;
                    end else if (wr_pend) begin
                        if (wr_first) begin
                            hold    <= wbuf;
                            half    <= 1'b1;
                            wr_pend <= 1'b0;
                        end else if (wr_block) begin
                            wr_pend  <= 1'b0;
                            pf_valid <= 1'b0;
                        end else begin
                            state <= ST_WR_REQ;
                        end
                    end else if (rd_pend) begin
                        if (!pf_valid) begin
                            state <= ST_RD_REQ;
                        end else if (pm && !half) begin
                            bus_out <= pf[WORD_W-1:LOW_W];
                            half    <= 1'b1;
                            rd_pend <= 1'b0;
                        end else begin
                            bus_out  <= pm ? {{(BUS_W-LOW_W){1'b0}}, pf[LOW_W-1:0]}
                                           : pf[BUS_W-1:0];
                            half     <= 1'b0;
                            rd_pend  <= 1'b0;
                            pf_valid <= 1'b0;
                            state    <= ST_RD_REQ;
                        end
                    end
                end
                ST_WR_REQ: if (mem_gnt) begin
                    half     <= 1'b0;
                    wr_pend  <= 1'b0;
                    pf_valid <= 1'b0;
                    state    <= ST_IDLE;
                end
                ST_RD_REQ: if (mem_gnt) state <= ST_RD_CAP;
                ST_RD_CAP: begin
                    pf       <= mem_rdata;
                    pf_valid <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a waiting request holds its address, type and direction
    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(addr) && $stable(mem_we) && $stable(pm)));

    a_r7_no_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !pm) |-> (int'(addr) < LIMIT));

    a_r9_ack_low_on_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ack);

    // R5: the first half of a program write never reaches memory
    a_r5_first_half_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_go && wr_first) |=> !mem_req);

endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
    import hostmem_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BUS_W     = 16,
    parameter int WORD_W    = 24,
    parameter int CTRL_REGS = 32,
    parameter int SYNC_FF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  h_bus_in,
    output logic [BUS_W-1:0]  h_bus_out,
    output logic              h_bus_oe,
    input  logic              h_latch,
    input  logic              h_sel,
    input  logic              h_rd,
    input  logic              h_wr,
    output logic              h_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pm,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int LIMIT = (1 << ADDR_W) - CTRL_REGS;

    hm_evt_t           evt;
    logic              ptr_load, ptr_inc;
    logic [ADDR_W-1:0] addr;
    logic              pm;

    hostmem_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst(rst), .h_latch(h_latch), .h_sel(h_sel),
        .h_rd(h_rd), .h_wr(h_wr), .evt(evt)
    );

    hostmem_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .load(ptr_load),
        .load_addr(h_bus_in[ADDR_W-1:0]), .load_pm(h_bus_in[ADDR_W]),
        .inc(ptr_inc), .addr(addr), .pm(pm)
    );

    hostmem_engine #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W), .LIMIT(LIMIT)
    ) u_eng (
        .clk(clk), .rst(rst), .evt(evt), .bus_in(h_bus_in),
        .addr(addr), .pm(pm), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
        .bus_out(h_bus_out), .ack(h_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    assign h_bus_oe = evt.rd_level;
    assign mem_pm   = pm;
    assign mem_addr = addr;

    // R1: nothing requested or driven right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && h_ack && !h_bus_oe));

endmodule

// File: tb/hostmem_port_test.sv
module hostmem_port_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] h_bus_in;
    logic [15:0] h_bus_out;
    logic        h_bus_oe, h_latch, h_sel, h_rd, h_wr, h_ack;
    logic        mem_req, mem_we, mem_pm, mem_gnt;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;

    int checks = 0, fails = 0;
    int grants = 0, writes = 0, ack_viol = 0, cyc = 0;
    int gnt_div = 3;
    bit done = 1'b0;

    logic [15:0] dmm [int];
    logic [23:0] pmm [int];

    always #5 clk = ~clk;

    hostmem_port uut (
        .clk(clk), .rst(rst), .h_bus_in(h_bus_in), .h_bus_out(h_bus_out),
        .h_bus_oe(h_bus_oe), .h_latch(h_latch), .h_sel(h_sel), .h_rd(h_rd),
        .h_wr(h_wr), .h_ack(h_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_pm(mem_pm), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    assign mem_gnt = mem_req && (cyc % gnt_div == 0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt) begin
            grants <= grants + 1;
            if (mem_we) begin
                writes <= writes + 1;
                if (mem_pm) pmm[int'(mem_addr)] = mem_wdata;
                else        dmm[int'(mem_addr)] = mem_wdata[15:0];
            end else begin
                if (mem_pm) mem_rdata <= pmm.exists(int'(mem_addr)) ? pmm[int'(mem_addr)] : 24'h0;
                else        mem_rdata <= dmm.exists(int'(mem_addr)) ? {8'h0, dmm[int'(mem_addr)]} : 24'h0;
            end
        end
    end

    always @(negedge clk) if (!rst && mem_req && h_ack) ack_viol++;

    task automatic report;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            report();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_ack(output bit saw_low);
        saw_low = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (!h_ack) saw_low = 1'b1;
        end
        while (!h_ack) @(negedge clk);
    endtask

    task automatic host_latch(input logic [13:0] a, input logic pmsel);
        bit lo;
        @(negedge clk);
        h_bus_in = {1'b0, pmsel, a};
        h_latch  = 1'b1;
        repeat (4) @(negedge clk);
        h_latch = 1'b0;
        wait_ack(lo);
        repeat (2) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] d, output bit saw_low);
        @(negedge clk);
        h_bus_in = d;
        h_sel = 1'b1; h_wr = 1'b1;
        wait_ack(saw_low);
        h_sel = 1'b0; h_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(output logic [15:0] d);
        bit lo;
        @(negedge clk);
        h_sel = 1'b1; h_rd = 1'b1;
        wait_ack(lo);
        @(negedge clk);
        d = h_bus_out;
        h_sel = 1'b0; h_rd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 ack", 32'(h_ack), 32'd1);
        check("R1 req", 32'(mem_req), 32'd0);
        check("R1 oe", 32'(h_bus_oe), 32'd0);
    endtask

    task automatic t_dm_read;
        logic [15:0] d;
        int g0;
        for (int i = 0; i < 4; i++) dmm[100 + i] = 16'hA000 + 16'(i * 17);
        g0 = grants;
        host_latch(14'd100, 1'b0);
        for (int i = 0; i < 4; i++) begin
            host_read(d);
            check("R4 dm burst read", 32'(d), 32'(16'hA000 + 16'(i * 17)));
        end
        check("R2 latch prefetch plus R8 one grant per read", 32'(grants - g0), 32'd5);
    endtask

    task automatic t_dm_write;
        int g0;
        bit lo;
        g0 = grants;
        host_latch(14'd200, 1'b0);
        g0 = grants;
        host_write(16'h1357, lo);
        check("R9 ack fell during write", 32'(lo), 32'd1);
        host_write(16'h2468, lo);
        host_write(16'hBEEF, lo);
        check("R3 dm write 200", 32'(dmm[200]), 32'h1357);
        check("R3 dm write 201", 32'(dmm[201]), 32'h2468);
        check("R3 dm write 202", 32'(dmm[202]), 32'hBEEF);
        check("R8 grants for 3 writes", 32'(grants - g0), 32'd3);
    endtask

    task automatic t_pm_write;
        int w0;
        bit lo;
        host_latch(14'd50, 1'b1);
        w0 = writes;
        host_write(16'h1234, lo);
        check("R5 no write after first half", 32'(writes - w0), 32'd0);
        host_write(16'hFF56, lo);
        check("R5 pm word 50", 32'(pmm[50]), 32'h123456);
        host_write(16'hABCD, lo);
        host_write(16'h0078, lo);
        check("R5 pm word 51 after pair increment", 32'(pmm[51]), 32'hABCD78);
    endtask

    task automatic t_pm_read;
        logic [15:0] d;
        pmm[300] = 24'hC3A5F0;
        pmm[301] = 24'h0102FE;
        host_latch(14'd300, 1'b1);
        host_read(d); check("R6 pm hi 300", 32'(d), 32'hC3A5);
        host_read(d); check("R6 pm lo 300", 32'(d), 32'h00F0);
        host_read(d); check("R6 pm hi 301", 32'(d), 32'h0102);
        host_read(d); check("R6 pm lo 301", 32'(d), 32'h00FE);
    endtask

    task automatic t_protect;
        logic [15:0] d;
        int w0;
        bit lo;
        dmm[16351] = 16'h7777;
        dmm[16352] = 16'h5555;
        dmm[16353] = 16'h6666;
        host_latch(14'd16351, 1'b0);
        w0 = writes;
        host_write(16'h1111, lo);
        host_write(16'h2222, lo);
        host_write(16'h3333, lo);
        check("R7 last open word written", 32'(dmm[16351]), 32'h1111);
        check("R7 single write issued", 32'(writes - w0), 32'd1);
        host_latch(14'd16352, 1'b0);
        host_read(d); check("R7 ctrl 16352 unchanged", 32'(d), 32'h5555);
        host_read(d); check("R7 ctrl 16353 unchanged, pointer advanced", 32'(d), 32'h6666);
    endtask

    task automatic t_pm_top;
        bit lo;
        host_latch(14'd16383, 1'b1);
        host_write(16'h9A9B, lo);
        host_write(16'h009C, lo);
        check("R10 pm top written", 32'(pmm[16383]), 32'h9A9B9C);
    endtask

    task automatic t_slow_grant;
        logic [15:0] d;
        bit lo;
        gnt_div = 7;
        host_latch(14'd400, 1'b0);
        host_write(16'h4242, lo);
        check("R9 ack low under slow grant", 32'(lo), 32'd1);
        host_latch(14'd400, 1'b0);
        host_read(d);
        check("R8 slow grant readback", 32'(d), 32'h4242);
        check("R9 ack high when idle", 32'(h_ack), 32'd1);
        check("R9 ack never high with request", 32'(ack_viol), 32'd0);
        gnt_div = 3;
    endtask

    initial begin
        rst = 1'b1;
        h_bus_in = '0; h_latch = 1'b0; h_sel = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dm_read();
        t_dm_write();
        t_pm_write();
        t_pm_read();
        t_protect();
        t_pm_top();
        t_slow_grant();
        done = 1'b1;
        report();
    end
endmodule